// File: doc/BRIEF.md
# Glitch-Free Segmented Delay-Code Updater

This block sits between a loop controller and a segmented, digitally controlled delay line inside an oscillator. The controller presents an 11-bit period code at any time. The five low bits adjust the fine load of the line. Each of the six high bits picks, for one coarse segment, whether that segment's delay element is inserted or bypassed. The first three segments hold large delay elements of different sizes. The last three hold 4, 2 and 1 gate delays.

Everything runs on the oscillator's own clock. The requested coarse bits are first captured into per-segment shadow storage. Each segment then adopts its shadow bit only in a cycle where its tap reports that the running clock edge has already left that segment. Segments adopt their new bits strictly from first to last. Because the line is binary weighted, each select output drives its segment's path gating directly, with no decoder in between. A busy flag reports that some segment still has a change waiting.

Top module: `seg_code_updater`

## Requirements
- R1: A clock edge with rst_n low clears every segment select and every fine bit to 0, which is the minimum-delay code, and busy reads 0 after it.
- R2: The fine bits req_code[4:0] sampled at a clock edge appear on fine_sel after that edge and stay until the next edge.
- R3: A segment select changes only at an edge where that segment's tap input is sampled high. With all taps low, the selects hold, no matter what is requested.
- R4: Segments adopt pending changes in order from first (index 0) to last. Segment i can change only at an edge where every segment below i already matches its shadow bit.
- R5: req_code[10:5] is captured into the shadow bits at every edge. A segment takes its shadow bit at the first edge after the capture where it is the lowest pending segment and its tap is high, so the earliest a new coarse bit can take effect is the second edge after it is presented.
- R6: busy is 1 exactly when at least one segment select differs from its captured shadow bit.
- R7: A tap pulse on a segment whose select already equals its shadow bit leaves that select unchanged.
- R8: Request bit 5+i drives seg_sel[i] directly, with no decoding. A 1 inserts the segment's delay element. A 0 bypasses the element and keeps it gated off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock; all state updates on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_code | input | 11 | Requested period code: [10:5] coarse, [4:0] fine |
| seg_tap | input | 6 | Per-segment flag: the clock edge has left segment i in this cycle |
| seg_sel | output | 6 | Applied coarse select for each segment; 1 inserts the delay element |
| fine_sel | output | 5 | Applied fine load code |
| busy | output | 1 | High while any segment still has a change pending |

## Verification
The fine code is due one edge after it is presented. A coarse bit is due no earlier than the second edge: one edge to capture it, then the first later edge where that segment is the lowest pending one and its tap is high. Busy follows the registered selects and shadow bits with no further delay. The bench drives its inputs on the falling edge and advances a behavioural model, which tracks the lowest pending index, on the rising edge. It compares all three outputs on the next falling edge. Directed phases hold taps low, fire taps out of order, and fire taps on settled segments, then check the selects against literal values at those same falling edges.

// File: rtl/seg_code_pkg.sv
// Package seg_code_pkg
// Purpose : default sizes shared by the delay-code updater and its submodules.
// Assumes : coarse segment count plus fine width gives the full code width.
package seg_code_pkg;
    localparam int unsigned SEG_COUNT  = 6;
    localparam int unsigned FINE_WIDTH = 5;
    localparam int unsigned CODE_WIDTH = SEG_COUNT + FINE_WIDTH;
endpackage

// File: rtl/code_capture.sv
// Module  : code_capture
// Purpose : registers the requested code on the oscillator clock. The coarse
//           part goes to per-segment shadow bits, the fine part straight to
//           the fine output, which takes effect in the next cycle.
// Assumes : req_code is stable around the rising edge of clk.
module code_capture #(
    parameter int unsigned SEG_N  = seg_code_pkg::SEG_COUNT,
    parameter int unsigned FINE_N = seg_code_pkg::FINE_WIDTH,
    localparam int unsigned CODE_N = SEG_N + FINE_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_N-1:0] req_code,
    output logic [SEG_N-1:0]  shadow,
    output logic [FINE_N-1:0] fine_q
);

    // Capture coarse request into shadow storage and apply fine bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '0;
            fine_q <= '0;
        end else begin
            shadow <= req_code[CODE_N-1:FINE_N];
            fine_q <= req_code[FINE_N-1:0];
        end
    end

    AST_FINE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (fine_q == $past(req_code[FINE_N-1:0])))
        else $error("fine bits not applied one cycle later"); // R2

endmodule

// File: rtl/seg_lane.sv
// Module  : seg_lane
// Purpose : holds the active select of one coarse segment. It adopts the
//           shadow bit only when the edge has left this segment (tap high)
//           and every earlier segment has already settled.
// Assumes : tap is a synchronous per-cycle flag from the delay line.
module seg_lane (
    input  logic clk,
    input  logic rst_n,
    input  logic tap,
    input  logic lower_clear,
    input  logic shadow_bit,
    output logic sel
);

    logic take;

    // Transfer is allowed only after the edge passed and lower lanes settled.
    always_comb take = tap && lower_clear;

    // Active select register; reset picks the bypass (minimum-delay) path.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel <= 1'b0;
        else if (take)
            sel <= shadow_bit;
    end

    AST_NO_MIDFLIGHT_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (sel != $past(sel))) |-> $past(tap))
        else $error("segment select changed with no tap"); // R3

    AST_SETTLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(sel) == $past(shadow_bit))) |-> $stable(sel))
        else $error("settled segment select moved"); // R7

endmodule

// File: rtl/seg_code_updater.sv
// Module  : seg_code_updater
// Purpose : applies a requested period code to a segmented delay line
//           without glitches. Fine bits are registered once. Coarse bits pass
//           through shadow storage and reach each segment's select in first-
//           to-last order, each only after the edge has left that segment.
// Assumes : clk is the oscillator clock itself; seg_tap[i] is high in a cycle
//           where the edge has left segment i.
module seg_code_updater #(
    parameter int unsigned SEG_N  = seg_code_pkg::SEG_COUNT,
    parameter int unsigned FINE_N = seg_code_pkg::FINE_WIDTH,
    localparam int unsigned CODE_N = SEG_N + FINE_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_N-1:0] req_code,
    input  logic [SEG_N-1:0]  seg_tap,
    output logic [SEG_N-1:0]  seg_sel,
    output logic [FINE_N-1:0] fine_sel,
    output logic              busy
);

    logic [SEG_N-1:0] shadow;
    logic [SEG_N-1:0] pend;
    logic [SEG_N:0]   clear_upto;

    code_capture #(.SEG_N(SEG_N), .FINE_N(FINE_N)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_code (req_code),
        .shadow   (shadow),
        .fine_q   (fine_sel)
    );

    // Per-segment mismatch between applied select and captured request.
    always_comb pend = seg_sel ^ shadow;

    // Pending flag drives the busy output.
    always_comb busy = |pend;

    assign clear_upto[0] = 1'b1;

    genvar gi;
    generate
        for (gi = 0; gi < SEG_N; gi++) begin : g_lane
            // Prefix chain: no earlier segment still pending.
            assign clear_upto[gi+1] = clear_upto[gi] & ~pend[gi];

            seg_lane u_lane (
                .clk         (clk),
                .rst_n       (rst_n),
                .tap         (seg_tap[gi]),
                .lower_clear (clear_upto[gi]),
                .shadow_bit  (shadow[gi]),
                .sel         (seg_sel[gi])
            );
        end

        for (gi = 1; gi < SEG_N; gi++) begin : g_order_chk
            AST_FIRST_TO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && (seg_sel[gi] != $past(seg_sel[gi])))
                    |-> ($past(pend[gi-1:0]) == '0))
                else $error("segment changed before lower segments settled"); // R4
        end
    endgenerate

    AST_RESET_MIN_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> ((seg_sel == '0) && (fine_sel == '0) && !busy))
        else $error("reset did not leave minimum-delay code"); // R1

endmodule

// File: tb/sim_seg_code_updater.sv
module sim_seg_code_updater;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] req_code = '0;
    logic [5:0]  seg_tap = '0;
    logic [5:0]  seg_sel;
    logic [4:0]  fine_sel;
    logic        busy;

    int tests = 0;
    int fails = 0;
    bit chk_on = 1'b0;
    bit done = 1'b0;

    // Behavioural reference state
    logic [5:0] m_act = '0;
    logic [5:0] m_shd = '0;
    logic [4:0] m_fine = '0;

    always #5 clk = ~clk;

    seg_code_updater u0 (
        .clk(clk), .rst_n(rst_n), .req_code(req_code), .seg_tap(seg_tap),
        .seg_sel(seg_sel), .fine_sel(fine_sel), .busy(busy)
    );

    // Reference: only the lowest pending segment may move, and only on its tap.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_act = '0; m_shd = '0; m_fine = '0;
        end else begin
            int first;
            first = -1;
            for (int k = 0; k < 6; k++)
                if (first < 0 && m_act[k] != m_shd[k]) first = k;
            if (first >= 0 && seg_tap[first]) m_act[first] = m_shd[first];
            m_shd  = req_code[10:5];
            m_fine = req_code[4:0];
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic [10:0] r, input logic [5:0] t);
        @(negedge clk);
        if (chk_on) begin
            check("R5 seg_sel vs model", seg_sel, m_act);
            check("R2 fine_sel vs model", fine_sel, m_fine);
            check("R6 busy vs model", busy, (m_act != m_shd));
        end
        req_code = r;
        seg_tap  = t;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: state right after reset
        check("R1 seg_sel after reset", seg_sel, 0);
        check("R1 fine_sel after reset", fine_sel, 0);
        check("R1 busy after reset", busy, 0);
        chk_on = 1'b1;

        // R8: coarse bits map straight to segment selects
        for (int n = 0; n < 8; n++) step({6'b100101, 5'h00}, 6'b111111);
        step({6'b100101, 5'h00}, 6'b000000);
        check("R8 direct bit mapping", seg_sel, 6'b100101);
        check("R6 idle after settle", busy, 0);

        // R4: seg0 and seg3 pending; only seg3 taps fire
        for (int n = 0; n < 5; n++) step({6'b101100, 5'h00}, 6'b001000);
        step({6'b101100, 5'h00}, 6'b000000);
        check("R4 seg3 waits for seg0", seg_sel, 6'b100101);
        check("R4 busy while waiting", busy, 1);
        step({6'b101100, 5'h00}, 6'b000001);
        step({6'b101100, 5'h00}, 6'b001000);
        step({6'b101100, 5'h00}, 6'b000000);
        check("R4 seg0 then seg3", seg_sel, 6'b101100);

        // R3: no taps, selects must hold
        for (int n = 0; n < 8; n++) step({6'b010011, 5'h00}, 6'b000000);
        check("R3 hold without taps", seg_sel, 6'b101100);
        check("R6 busy with pending", busy, 1);
        for (int n = 0; n < 8; n++) step({6'b010011, 5'h00}, 6'b111111);
        step({6'b010011, 5'h00}, 6'b000000);
        check("R5 applied after taps", seg_sel, 6'b010011);

        // R7: taps on settled segments change nothing
        for (int n = 0; n < 5; n++) step({6'b010011, 5'h00}, 6'b111111);
        check("R7 settled taps", seg_sel, 6'b010011);

        // R2: fine bits one cycle later
        step({6'b010011, 5'h15}, 6'b000000);
        step({6'b010011, 5'h15}, 6'b000000);
        check("R2 fine latency", fine_sel, 5'h15);

        // Mixed traffic compared against the model every cycle
        begin
            logic [10:0] r;
            r = {6'b010011, 5'h15};
            for (int n = 0; n < 3000; n++) begin
                if (($urandom % 8) == 0) r = 11'($urandom);
                step(r, 6'($urandom));
            end
        end
        step(req_code, 6'b000000);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired at %0t", $time);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule